// File: doc/BRIEF.md
# Memory-Based Pattern Sequencer

The block stores a multi-track output pattern in an internal memory and plays it on a parallel output, one word at a time, in its own sequencer clock domain. A single-master byte-wide register bus loads the pattern and a small set of control registers. Software then starts playback with a register write, or hardware starts it with a rising edge on a qualified start pin. A done bit can be read back over the same bus.

Playback supports a clock divider that sets how long each word is held. It has a programmable sequence length and an outer repeat loop with a programmable gap between passes. Every pass after the first re-enters at a programmable word. An inner loop replays a sub-range of words a programmable number of times within each pass. When playback ends, the output keeps its last word. A soft reset stops playback and clears the output.

Configuration is quasi-static: it is written while the sequencer is idle and read directly by the sequencer domain. Start and soft-reset requests cross to the sequencer domain as toggles. Completion returns to the bus domain as a toggle acknowledge and a synchronised busy level.

Top module: `pattern_sequencer`

## Requirements
- R1: A bus write to address 1 starts playback. A read of address 1 returns the done flag in bit 0. Done reads 0 on the first read after the start write and stays 0 until every pass has finished; it reads 1 out of reset.
- R2: When bit 0 of address 2 is 1, a rising edge on `ext_start` starts playback. If `ext_start` rises right after a falling sequencer-clock edge, word 0 appears on `seq_out` at the fourth following falling edge. When the bit is 0, the pin has no effect.
- R3: Each played word stays on `seq_out` for exactly DIV+1 sequencer cycles, where DIV is the byte at address 3.
- R4: A pass plays words 0 to LEN-1 in order. LEN is the 32-bit value at addresses 4 to 7. Word i is held in bytes 64+i*B up to 64+i*B+B-1, where B is OUT_BITS/8, and the lowest address holds the least significant byte.
- R5: The 32-bit value at addresses 12 to 15 gives the number of passes. A value of 0 repeats until a soft reset, and done stays 0 during that time.
- R6: Every pass after the first starts at the word given at addresses 16 to 19. Between passes, the last word of the pass is held for an additional GAP cycles, where GAP is the value at addresses 8 to 11.
- R7: When the count C at addresses 28 to 31 is 2 or more and FIRST ≤ LAST (addresses 20 to 23 and 24 to 27), the words FIRST to LAST are played C times in total within each pass. After that, playback continues past LAST.
- R8: After the last pass, `seq_out` keeps the final word and done reads 1.
- R9: A write to address 0 stops playback, clears `seq_out` to 0, and returns done to 1. A read of address 0 returns the VERSION parameter.
- R10: A start request that arrives while playback runs, or while LEN is 0, is ignored. The running output stream is unchanged, and with LEN 0 the output and done stay as they were.
- R11: The control bytes at addresses 2 to 31 read back as written. Multi-byte values are little-endian. After reset, LEN is MEM_BYTES/B, the pass count is 1 and the other bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Synchronous active-low reset, bus domain |
| seq_clk | input | 1 | Sequencer clock |
| seq_rst_n | input | 1 | Synchronous active-low reset, sequencer domain |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after the read strobe |
| ext_start | input | 1 | External start, synchronous to `seq_clk` |
| seq_out | output | OUT_BITS | Pattern output |

## Verification
Read data is due one bus clock after the read strobe, so every bus read samples at the following falling bus edge. With the external start pin, the first word is due on `seq_out` four falling sequencer edges after the pin rises. After that, each word lasts DIV+1 cycles and each gap adds GAP cycles. The bench therefore starts every stream check from the pin and compares the output at every falling sequencer edge against a stream that a bench function builds cycle by cycle. Software starts and soft resets cross clock domains, and their timing is not fixed to the cycle. Their results are checked by polling the done bit, followed by a comparison of the held output.

// File: rtl/seqgen_pkg.sv
// Shared types for the pattern sequencer.
// Assumes: byte-wide register bus and little-endian multi-byte registers.
package seqgen_pkg;

    localparam int REG_BYTES = 32;   // control byte window
    localparam int MEM_BASE  = 64;   // first pattern byte address

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic        ext_en;
        logic [7:0]  clk_div;
        logic [31:0] length;
        logic [31:0] gap;
        logic [31:0] passes;
        logic [31:0] reentry;
        logic [31:0] loop_first;
        logic [31:0] loop_last;
        logic [31:0] loop_count;
    } seq_cfg_t;

endpackage

// File: rtl/seq_sync.sv
// Two-flop level synchroniser into the clock domain of clk.
// Assumes: the input is a level or toggle that holds for several destination cycles.
module seq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // capture then re-register to settle metastability
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/seq_regfile.sv
// Bus-domain register file and pattern memory of the sequencer.
// Decodes byte writes and reads. Keeps the start and soft-reset toggles.
// Forms the done flag from the returned acknowledge and busy level.
// Assumes: starts are spaced so that each one is acknowledged before the next.
module seq_regfile
    import seqgen_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter int         MEM_BYTES  = 64,
    parameter int         WORD_BYTES = 1,
    parameter int         IDX_W      = 6,
    parameter logic [7:0] VERSION    = 8'h21
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [7:0]                bus_wdata,
    output logic [7:0]                bus_rdata,
    output seq_cfg_t                  cfg,
    input  logic [IDX_W-1:0]          word_idx,
    output logic [8*WORD_BYTES-1:0]   word_data,
    output logic                      req_tgl,
    output logic                      srst_tgl,
    input  logic                      ack_sync,
    input  logic                      busy_sync
);
    localparam int          WORD_CNT = MEM_BYTES / WORD_BYTES;
    localparam int          MIDX_W   = $clog2(MEM_BYTES);
    localparam logic [31:0] LEN_DEF  = 32'(WORD_CNT);

    logic [7:0]        cfgb [2:REG_BYTES-1];
    logic [7:0]        mem  [MEM_BYTES];
    logic [MIDX_W-1:0] mem_off;
    logic [MIDX_W-1:0] byte_base;
    logic              in_regs;
    logic              in_mem;
    logic              done;

    function automatic logic [31:0] le32(input int b);
        return {cfgb[b+3], cfgb[b+2], cfgb[b+1], cfgb[b]};
    endfunction

    // address decode for the control window and the pattern window
    always_comb begin
        in_regs = (bus_addr >= ADDR_W'(2)) && (bus_addr < ADDR_W'(REG_BYTES));
        in_mem  = (bus_addr >= ADDR_W'(MEM_BASE)) &&
                  (bus_addr <  ADDR_W'(MEM_BASE + MEM_BYTES));
        mem_off = MIDX_W'(bus_addr - ADDR_W'(MEM_BASE));
    end

    // control bytes and request toggles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 2; i < REG_BYTES; i++) cfgb[i] <= 8'd0;
            cfgb[4]  <= LEN_DEF[7:0];
            cfgb[5]  <= LEN_DEF[15:8];
            cfgb[6]  <= LEN_DEF[23:16];
            cfgb[7]  <= LEN_DEF[31:24];
            cfgb[12] <= 8'd1;
            req_tgl  <= 1'b0;
            srst_tgl <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(0))      srst_tgl <= ~srst_tgl;
            else if (bus_addr == ADDR_W'(1)) req_tgl  <= ~req_tgl;
            else if (in_regs)                cfgb[bus_addr[4:0]] <= bus_wdata;
        end
    end

    // pattern storage written from the bus
    always_ff @(posedge clk) begin
        if (bus_wr && in_mem) mem[mem_off] <= bus_wdata;
    end

    // done: no outstanding software start and the sequencer not busy
    assign done = (ack_sync == req_tgl) && !busy_sync;

    // registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= 8'd0;
        end else if (bus_rd) begin
            if (bus_addr == ADDR_W'(0))      bus_rdata <= VERSION;
            else if (bus_addr == ADDR_W'(1)) bus_rdata <= {7'd0, done};
            else if (in_regs)                bus_rdata <= cfgb[bus_addr[4:0]];
            else if (in_mem)                 bus_rdata <= mem[mem_off];
            else                             bus_rdata <= 8'd0;
        end
    end

    // configuration fields seen by the sequencer domain
    always_comb begin
        cfg.ext_en     = cfgb[2][0];
        cfg.clk_div    = cfgb[3];
        cfg.length     = le32(4);
        cfg.gap        = le32(8);
        cfg.passes     = le32(12);
        cfg.reentry    = le32(16);
        cfg.loop_first = le32(20);
        cfg.loop_last  = le32(24);
        cfg.loop_count = le32(28);
    end

    // pattern word assembled little-endian from consecutive bytes
    assign byte_base = MIDX_W'(word_idx * WORD_BYTES);
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_word
        assign word_data[8*b +: 8] = mem[byte_base + MIDX_W'(b)];
    end

    // R1: a start write that is accepted makes done read 0 at once
    assert_done_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(1) && ack_sync == req_tgl) |=> !done);

endmodule

// File: rtl/seq_engine.sv
// Sequencer-domain playback engine: start detection, clock divider,
// word pointer with inner and outer loops, gap timer and output register.
// Assumes: cfg is stable while the engine is not idle.
module seq_engine
    import seqgen_pkg::*;
#(
    parameter int OUT_BITS = 8,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  seq_cfg_t            cfg,
    input  logic                sw_req,
    input  logic                srst_lvl,
    input  logic                ext_pin,
    output logic [IDX_W-1:0]    word_idx,
    input  logic [OUT_BITS-1:0] word_data,
    output logic [OUT_BITS-1:0] seq_out,
    output logic                busy,
    output logic                ack
);
    seq_state_e  state;
    logic [31:0] ptr, pass_cnt, inner_left, gap_cnt;
    logic [7:0]  div_cnt;
    logic        req_last, srst_last, ext_s1, ext_s2, ext_prev;
    logic        sw_start, srst_p, ext_rise, start_any;
    logic        last_div, inner_on, jump_inner, pass_end, final_pass;
    logic [31:0] inner_reload;

    // request and edge decode
    always_comb begin
        sw_start     = sw_req != req_last;
        srst_p       = srst_lvl != srst_last;
        ext_rise     = ext_s2 && !ext_prev && cfg.ext_en;
        start_any    = sw_start || ext_rise;
        last_div     = div_cnt == cfg.clk_div;
        inner_on     = (cfg.loop_count > 32'd1) && (cfg.loop_first <= cfg.loop_last);
        jump_inner   = inner_on && (ptr == cfg.loop_last) && (inner_left != 32'd0);
        pass_end     = ptr >= cfg.length - 32'd1;
        final_pass   = (cfg.passes != 32'd0) && (pass_cnt + 32'd1 == cfg.passes);
        inner_reload = (cfg.loop_count > 32'd1) ? cfg.loop_count - 32'd1 : 32'd0;
    end

    assign word_idx = ptr[IDX_W-1:0];
    assign busy     = state != ST_IDLE;

    // edge-detect registers for requests and the external pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_last  <= 1'b0;
            srst_last <= 1'b0;
            ext_s1    <= 1'b0;
            ext_s2    <= 1'b0;
            ext_prev  <= 1'b0;
        end else begin
            req_last  <= sw_req;
            srst_last <= srst_lvl;
            ext_s1    <= ext_pin;
            ext_s2    <= ext_s1;
            ext_prev  <= ext_s2;
        end
    end

    // playback state machine, counters and output word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ptr        <= 32'd0;
            pass_cnt   <= 32'd0;
            inner_left <= 32'd0;
            gap_cnt    <= 32'd0;
            div_cnt    <= 8'd0;
            seq_out    <= '0;
            ack        <= 1'b0;
        end else if (srst_p) begin
            state      <= ST_IDLE;
            ptr        <= 32'd0;
            pass_cnt   <= 32'd0;
            inner_left <= 32'd0;
            gap_cnt    <= 32'd0;
            div_cnt    <= 8'd0;
            seq_out    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_any && cfg.length != 32'd0) begin
                        state      <= ST_RUN;
                        ptr        <= 32'd0;
                        div_cnt    <= 8'd0;
                        pass_cnt   <= 32'd0;
                        inner_left <= inner_reload;
                    end else begin
                        ack <= req_last;
                    end
                end
                ST_RUN: begin
                    if (div_cnt == 8'd0) seq_out <= word_data;
                    if (last_div) begin
                        div_cnt <= 8'd0;
                        if (jump_inner) begin
                            ptr        <= cfg.loop_first;
                            inner_left <= inner_left - 32'd1;
                        end else if (pass_end) begin
                            if (final_pass) begin
                                state <= ST_IDLE;
                            end else begin
                                pass_cnt   <= pass_cnt + 32'd1;
                                inner_left <= inner_reload;
                                gap_cnt    <= 32'd0;
                                if (cfg.gap == 32'd0) ptr <= cfg.reentry;
                                else                  state <= ST_GAP;
                            end
                        end else begin
                            ptr <= ptr + 32'd1;
                        end
                    end else begin
                        div_cnt <= div_cnt + 8'd1;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == cfg.gap - 32'd1) begin
                        state   <= ST_RUN;
                        ptr     <= cfg.reentry;
                        div_cnt <= 8'd0;
                    end else begin
                        gap_cnt <= gap_cnt + 32'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: the divider never passes the programmed hold count
    assert_div_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (div_cnt <= cfg.clk_div));

    // R2: a qualified pin edge while idle begins a pass at word 0
    assert_ext_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !srst_p && ext_rise && cfg.length != 32'd0)
        |=> (state == ST_RUN && ptr == 32'd0));

    // R6: the gap timer stays inside the programmed gap
    assert_gap_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (gap_cnt < cfg.gap));

    // R8: the output holds while idle
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !srst_p) |=> $stable(seq_out));

    // R9: soft reset clears the output and stops playback
    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_p |=> (seq_out == '0 && state == ST_IDLE));

    // R10: a start seen mid-word while running does not move the pointer
    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && start_any && !srst_p && !last_div) |=> $stable(ptr));

endmodule

// File: rtl/pattern_sequencer.sv
// Top of the pattern sequencer: bus-side register file and memory,
// handshake synchronisers, and the sequencer-domain playback engine.
// Assumes: OUT_BITS is a multiple of 8 and MEM_BYTES is a multiple of OUT_BITS/8.
// Control registers change only while the sequencer is idle.
module pattern_sequencer
    import seqgen_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         MEM_BYTES = 64,
    parameter int         OUT_BITS  = 8,
    parameter logic [7:0] VERSION   = 8'h21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seq_clk,
    input  logic                seq_rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic                ext_start,
    output logic [OUT_BITS-1:0] seq_out
);
    localparam int WORD_BYTES = OUT_BITS / 8;
    localparam int WORD_CNT   = MEM_BYTES / WORD_BYTES;
    localparam int IDX_W      = (WORD_CNT > 1) ? $clog2(WORD_CNT) : 1;

    seq_cfg_t            cfg;
    logic [IDX_W-1:0]    word_idx;
    logic [OUT_BITS-1:0] word_data;
    logic                req_tgl, srst_tgl, ack_seq, busy_seq;
    logic [1:0]          to_seq, in_seq, to_bus, in_bus;

    seq_regfile #(
        .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .WORD_BYTES(WORD_BYTES),
        .IDX_W(IDX_W), .VERSION(VERSION)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg(cfg), .word_idx(word_idx), .word_data(word_data),
        .req_tgl(req_tgl), .srst_tgl(srst_tgl),
        .ack_sync(in_bus[0]), .busy_sync(in_bus[1])
    );

    assign to_seq = {srst_tgl, req_tgl};
    assign to_bus = {busy_seq, ack_seq};

    seq_sync #(.W(2)) i_sync_to_seq (
        .clk(seq_clk), .rst_n(seq_rst_n), .d(to_seq), .q(in_seq)
    );

    seq_sync #(.W(2)) i_sync_to_bus (
        .clk(clk), .rst_n(rst_n), .d(to_bus), .q(in_bus)
    );

    seq_engine #(.OUT_BITS(OUT_BITS), .IDX_W(IDX_W)) i_engine (
        .clk(seq_clk), .rst_n(seq_rst_n), .cfg(cfg),
        .sw_req(in_seq[0]), .srst_lvl(in_seq[1]), .ext_pin(ext_start),
        .word_idx(word_idx), .word_data(word_data),
        .seq_out(seq_out), .busy(busy_seq), .ack(ack_seq)
    );

endmodule

// File: tb/test_pattern_sequencer.sv
module test_pattern_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int SEQ_PERIOD = 14;
    localparam int OB   = 16;
    localparam int MB   = 64;
    localparam int WC   = 32;
    localparam int MAXS = 2048;

    logic          clk = 0, seq_clk = 0, rst_n = 0, seq_rst_n = 0;
    logic          bus_wr = 0, bus_rd = 0, ext_start = 0;
    logic [15:0]   bus_addr = '0;
    logic [7:0]    bus_wdata = '0, bus_rdata;
    logic [OB-1:0] seq_out;

    int tests = 0, fails = 0;
    logic [15:0] pat   [WC];
    logic [15:0] exp_s [1:MAXS];
    logic [15:0] cap   [1:MAXS];
    int wr_n, exp_end;
    logic [15:0] exp_final;
    int b_div, b_len, b_gap, b_pass, b_re, b_lf, b_ll, b_lc, b_ext;

    pattern_sequencer #(.ADDR_W(16), .MEM_BYTES(MB), .OUT_BITS(OB), .VERSION(8'h21))
    i_pattern_sequencer (
        .clk(clk), .rst_n(rst_n), .seq_clk(seq_clk), .seq_rst_n(seq_rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_start(ext_start), .seq_out(seq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(SEQ_PERIOD/2) seq_clk = ~seq_clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic bus_write(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = 16'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = 16'(a);
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic set32(input int base, input logic [31:0] v);
        for (int i = 0; i < 4; i++) bus_write(base + i, v[8*i +: 8]);
    endtask

    task automatic cfg_apply();
        bus_write(2, 8'(b_ext));
        bus_write(3, 8'(b_div));
        set32(4,  32'(b_len));
        set32(8,  32'(b_gap));
        set32(12, 32'(b_pass));
        set32(16, 32'(b_re));
        set32(20, 32'(b_lf));
        set32(24, 32'(b_ll));
        set32(28, 32'(b_lc));
    endtask

    task automatic load_pattern();
        for (int i = 0; i < WC; i++) begin
            pat[i] = 16'($urandom);
            bus_write(64 + 2*i, pat[i][7:0]);
            bus_write(65 + 2*i, pat[i][15:8]);
        end
    endtask

    task automatic push(input logic [15:0] w);
        if (wr_n <= MAXS) begin exp_s[wr_n] = w; wr_n++; end
    endtask

    // expected per-cycle output stream, sample 1 is the first falling edge after the pin rises
    task automatic build_exp(input logic [15:0] prev);
        int ptr, inner, pass;
        logic [15:0] w, last;
        wr_n = 1; exp_end = 0; last = prev;
        repeat (3) push(prev);
        ptr = 0; pass = 0;
        inner = (b_lc > 1) ? b_lc - 1 : 0;
        while (wr_n <= MAXS) begin
            w = pat[ptr];
            for (int k = 0; k <= b_div; k++) push(w);
            last = w;
            if (b_lc > 1 && b_lf <= b_ll && ptr == b_ll && inner != 0) begin
                ptr = b_lf; inner--;
            end else if (ptr >= b_len - 1) begin
                pass++;
                if (b_pass != 0 && pass == b_pass) begin exp_end = wr_n - 1; break; end
                for (int k = 0; k < b_gap; k++) push(w);
                ptr = b_re;
                inner = (b_lc > 1) ? b_lc - 1 : 0;
            end else begin
                ptr++;
            end
        end
        while (wr_n <= MAXS) push(last);
        if (exp_end == 0) exp_end = MAXS;
        exp_final = last;
    endtask

    task automatic run_ext(input int nsamp, input bit repulse, input string req);
        int bad;
        @(negedge seq_clk);
        build_exp(seq_out);
        ext_start = 1;
        for (int i = 1; i <= nsamp; i++) begin
            @(negedge seq_clk);
            cap[i] = seq_out;
            if (i == 2) ext_start = 0;
            if (repulse && i == 20) ext_start = 1;
            if (repulse && i == 22) ext_start = 0;
        end
        bad = 0;
        for (int i = 1; i <= nsamp; i++) begin
            if (bad == 0 && cap[i] !== exp_s[i]) begin
                bad = i;
                chk($sformatf("%s stream sample %0d", req, i), 32'(cap[i]), 32'(exp_s[i]));
            end
        end
        if (bad == 0) chk(req, 32'd0, 32'd0);
    endtask

    task automatic wait_done(output logic [7:0] d);
        for (int i = 0; i < 4000; i++) begin
            bus_read(1, d);
            if (d[0]) break;
        end
    endtask

    task automatic finite_run(input string req);
        logic [7:0] d;
        cfg_apply();
        run_ext((exp_end_for() + 8 > MAXS) ? MAXS : exp_end_for() + 8, 0, req);
        wait_done(d);
        chk("R8 done after last pass", 32'(d[0]), 32'd1);
        chk("R8 output holds final word", 32'(seq_out), 32'(exp_final));
    endtask

    function automatic int exp_end_for();
        // upper bound of the stream length for the current settings
        int per_pass;
        per_pass = (b_len + ((b_lc > 1) ? (b_lc - 1) * (b_ll - b_lf + 1) : 0)) * (b_div + 1) + b_gap;
        return 3 + per_pass * b_pass;
    endfunction

    task automatic set_defaults();
        b_div = 0; b_len = 4; b_gap = 0; b_pass = 1; b_re = 0;
        b_lf = 0; b_ll = 0; b_lc = 0; b_ext = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [15:0] held;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1; seq_rst_n = 1;
        repeat (4) @(negedge clk);

        // reset state
        chk("R8 reset output", 32'(seq_out), 32'd0);
        bus_read(1, d); chk("R1 done after reset", 32'(d), 32'd1);
        bus_read(0, d); chk("R9 version", 32'(d), 32'h21);
        bus_read(4, d); chk("R11 length default", 32'(d), 32'(WC));
        bus_read(12, d); chk("R11 pass default", 32'(d), 32'd1);
        bus_read(20, d); chk("R11 loop start default", 32'(d), 32'd0);

        // little-endian readback
        set32(16, 32'h0403_0201);
        for (int i = 0; i < 4; i++) begin
            bus_read(16 + i, d);
            chk("R11 byte order", 32'(d), 32'(i + 1));
        end

        load_pattern();

        // software start
        set_defaults(); b_div = 3; b_pass = 2; b_gap = 10;
        cfg_apply();
        bus_write(1, 8'd0);
        bus_read(1, d); chk("R1 done drops after start", 32'(d[0]), 32'd0);
        wait_done(d);
        chk("R1 done returns", 32'(d[0]), 32'd1);
        chk("R8 sw run final word", 32'(seq_out), 32'(pat[3]));

        // external start disabled
        set_defaults(); b_ext = 0; cfg_apply();
        held = seq_out;
        @(negedge seq_clk); ext_start = 1;
        repeat (3) @(negedge seq_clk); ext_start = 0;
        repeat (20) @(negedge seq_clk);
        chk("R2 pin ignored when disabled", 32'(seq_out), 32'(held));
        bus_read(1, d); chk("R2 done unchanged when disabled", 32'(d[0]), 32'd1);

        // zero length ignored
        set_defaults(); b_len = 0; cfg_apply();
        @(negedge seq_clk); ext_start = 1;
        repeat (3) @(negedge seq_clk); ext_start = 0;
        repeat (20) @(negedge seq_clk);
        chk("R10 zero length output", 32'(seq_out), 32'(held));
        bus_read(1, d); chk("R10 zero length done", 32'(d[0]), 32'd1);

        // inner loop
        set_defaults(); b_len = 8; b_lf = 2; b_ll = 4; b_lc = 3;
        finite_run("R7 inner loop");

        // re-entry and gap
        set_defaults(); b_len = 6; b_re = 3; b_pass = 3; b_gap = 4; b_div = 1;
        finite_run("R6 re-entry with gap");

        // endless repeat with a second start while running
        set_defaults(); b_len = 5; b_gap = 2; b_pass = 0; b_div = 2;
        cfg_apply();
        run_ext(200, 1, "R5 R10 endless run with ignored restart");
        bus_read(1, d); chk("R5 done low while endless", 32'(d[0]), 32'd0);

        // soft reset
        bus_write(0, 8'd0);
        repeat (10) @(negedge seq_clk);
        chk("R9 soft reset clears output", 32'(seq_out), 32'd0);
        wait_done(d);
        chk("R9 done after soft reset", 32'(d[0]), 32'd1);

        // random configurations
        for (int t = 0; t < 6; t++) begin
            set_defaults();
            b_div  = int'($urandom_range(0, 3));
            b_len  = int'($urandom_range(1, WC));
            b_pass = int'($urandom_range(1, 3));
            b_gap  = int'($urandom_range(0, 5));
            b_re   = int'($urandom_range(0, b_len - 1));
            b_lc   = int'($urandom_range(0, 3));
            b_lf   = int'($urandom_range(0, b_len - 1));
            b_ll   = int'($urandom_range(b_lf, b_len - 1));
            if (t == 0) load_pattern();
            finite_run("R3 R4 random stream");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule